// File: doc/BRIEF.md
# Global Flash Write Protect Control

This block holds the chip-wide guard that decides whether the flash command path may program or erase the flash. It keeps three control bits: an unlock bit, which turns write protection off when set; a lock bit, which limits who may set the unlock bit; and an interrupt-enable bit, which reports attempts by ordinary code to get around the lock. All three are written through a single register write port. A side input tells the block whether the current access comes from system management mode.

The flash command path reads one permit output. That permit covers both program and erase commands. When locked code outside management mode tries to unlock the flash, the block refuses the change. If the interrupt-enable bit is set, it also raises a one-clock request toward the management interrupt logic. Clearing the unlock bit, which turns protection back on, is always accepted.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset the unlock, lock and interrupt-enable bits are all 0, so `prog_permit` is 0 and `smi_req` is 0.
- R2: `prog_permit` equals the stored unlock bit and is the single permit for both program and erase. It changes only in the cycle after an accepted write, and a cycle with `wr_en` low changes nothing.
- R3: Control word fields are unlock at bit 0, lock at bit 1 and interrupt-enable at bit 2. While the lock bit is 0, a write stores bit 0 into the unlock bit whatever the value of `mgmt_mode`.
- R4: While the lock bit is 1, a write with `mgmt_mode` high and bit 0 set stores 1 into the unlock bit.
- R5: While the lock bit is 1, a write with `mgmt_mode` low and bit 0 set leaves the unlock bit unchanged.
- R6: A write with bit 0 clear always stores 0 into the unlock bit, whatever the values of `mgmt_mode` and the lock bit.
- R7: A write with bit 1 set sets the lock bit. Once the lock bit is set, only reset clears it, and the lock applies to writes after the one that set it.
- R8: A write with `mgmt_mode` low and bit 0 set, made while the lock bit and the interrupt-enable bit are both already 1, raises `smi_req` for exactly the one cycle after that write. Back-to-back attempts give one pulse each.
- R9: `smi_req` stays low for writes that do not meet all the conditions of R8: the write comes from management mode, the interrupt-enable bit is 0, or the lock bit is 0.
- R10: The interrupt-enable bit takes bit 2 of a write only while the lock bit is 0. While the lock bit is 1, writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | DATA_W | Control word (bit 0 unlock, bit 1 lock, bit 2 interrupt enable) |
| mgmt_mode | input | 1 | High when the current access comes from system management mode |
| prog_permit | output | 1 | Program and erase commands may proceed |
| smi_req | output | 1 | One-cycle management interrupt request |

## Verification
The bench goes after the lock that is set in the same write as an unlock. A design that applied the lock at once would refuse that write or raise a false interrupt. It also checks that a lock or interrupt enable cannot be cleared by a later write; a design that got this wrong would let ordinary code unlock the flash without a report. Back-to-back blocked attempts must each give their own pulse, which exposes a pulse stretcher or an edge detector. A locked clear from ordinary code must still take effect, which exposes a design that froze the whole unlock bit under lock.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
    localparam int CTRL_W     = 3;
    localparam int UNLOCK_BIT = 0;
    localparam int LOCK_BIT   = 1;
    localparam int SMIEN_BIT  = 2;

    typedef struct packed {
        logic unlock;
        logic lock;
        logic smi_en;
        logic smi;
    } wpc_state_t;
endpackage

// File: rtl/wpc_policy.sv
// Next-value rules for the three stored control bits.
module wpc_policy (
    input  logic cur_unlock,
    input  logic cur_lock,
    input  logic cur_smi_en,
    input  logic wr_en,
    input  logic want_unlock,
    input  logic want_lock,
    input  logic want_smi_en,
    input  logic mgmt_mode,
    output logic nxt_unlock,
    output logic nxt_lock,
    output logic nxt_smi_en
);
    logic unlock_ok;

    always_comb begin
        // Clearing is always accepted; setting needs no lock or management mode.
        unlock_ok  = !want_unlock || !cur_lock || mgmt_mode;
        nxt_unlock = cur_unlock;
        nxt_lock   = cur_lock;
        nxt_smi_en = cur_smi_en;
        if (wr_en) begin
            if (unlock_ok) begin
                nxt_unlock = want_unlock;
            end
            nxt_lock = cur_lock | want_lock;
            if (!cur_lock) begin
                nxt_smi_en = want_smi_en;
            end
        end
    end
endmodule

// File: rtl/wpc_smi_detect.sv
// Flags a blocked unlock attempt from ordinary code.
module wpc_smi_detect (
    input  logic wr_en,
    input  logic want_unlock,
    input  logic mgmt_mode,
    input  logic cur_lock,
    input  logic cur_smi_en,
    output logic smi_trig
);
    logic blocked_attempt;

    always_comb begin
        blocked_attempt = wr_en && want_unlock && !mgmt_mode && cur_lock;
        smi_trig        = blocked_attempt && cur_smi_en;
    end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl #(
    parameter int DATA_W = wpc_pkg::CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mgmt_mode,
    output logic              prog_permit,
    output logic              smi_req
);
    import wpc_pkg::*;

    localparam int MIN_W = SMIEN_BIT + 1;

    generate
        if (DATA_W < MIN_W) begin : g_bad_width
            initial $error("DATA_W too narrow for control fields");
        end
    endgenerate

    wpc_state_t st_d, st_q;
    logic nxt_unlock, nxt_lock, nxt_smi_en, smi_trig;

    wpc_policy u_policy (
        .cur_unlock (st_q.unlock),
        .cur_lock   (st_q.lock),
        .cur_smi_en (st_q.smi_en),
        .wr_en      (wr_en),
        .want_unlock(wr_data[UNLOCK_BIT]),
        .want_lock  (wr_data[LOCK_BIT]),
        .want_smi_en(wr_data[SMIEN_BIT]),
        .mgmt_mode  (mgmt_mode),
        .nxt_unlock (nxt_unlock),
        .nxt_lock   (nxt_lock),
        .nxt_smi_en (nxt_smi_en)
    );

    wpc_smi_detect u_smi (
        .wr_en      (wr_en),
        .want_unlock(wr_data[UNLOCK_BIT]),
        .mgmt_mode  (mgmt_mode),
        .cur_lock   (st_q.lock),
        .cur_smi_en (st_q.smi_en),
        .smi_trig   (smi_trig)
    );

    always_comb begin
        st_d        = st_q;
        st_d.unlock = nxt_unlock;
        st_d.lock   = nxt_lock;
        st_d.smi_en = nxt_smi_en;
        st_d.smi    = smi_trig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prog_permit = st_q.unlock;
    assign smi_req     = st_q.smi;
endmodule

// File: rtl/flash_wp_ctrl_chk.sv
module flash_wp_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic want_unlock,
    input logic want_lock,
    input logic mgmt_mode,
    input logic prog_permit,
    input logic smi_req
);
    logic lock_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_seen_q <= 1'b0;
        end else if (wr_en && want_lock) begin
            lock_seen_q <= 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!prog_permit && !smi_req));

    assert_permit_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prog_permit) |-> $past(wr_en));

    assert_clear_always_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !want_unlock) |=> !prog_permit);

    assert_locked_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_seen_q && wr_en && !mgmt_mode && !prog_permit) |=> !prog_permit);

    assert_mgmt_unlock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && want_unlock && mgmt_mode) |=> prog_permit);

    assert_smi_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> $past(wr_en && want_unlock && !mgmt_mode));

    assert_smi_needs_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> lock_seen_q);
endmodule

bind flash_wp_ctrl flash_wp_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .want_unlock(wr_data[wpc_pkg::UNLOCK_BIT]),
    .want_lock  (wr_data[wpc_pkg::LOCK_BIT]),
    .mgmt_mode  (mgmt_mode),
    .prog_permit(prog_permit),
    .smi_req    (smi_req)
);

// File: tb/tb_flash_wp_ctrl.sv
`timescale 1ns/1ps
module tb_flash_wp_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_data = 3'b000;
    logic       mgmt_mode = 1'b0;
    logic       prog_permit, smi_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit m_unlock, m_lock, m_smien, m_smi;

    always #2 clk = ~clk;

    flash_wp_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .mgmt_mode(mgmt_mode), .prog_permit(prog_permit), .smi_req(smi_req)
    );

    task automatic compare(input string tag);
        checks++;
        if (prog_permit !== m_unlock) begin
            errors++;
            $display("FAIL %s prog_permit actual=%b expected=%b", tag, prog_permit, m_unlock);
        end
        checks++;
        if (smi_req !== m_smi) begin
            errors++;
            $display("FAIL %s smi_req actual=%b expected=%b", tag, smi_req, m_smi);
        end
    endtask

    task automatic model_edge(input bit w, input bit [2:0] d, input bit mg);
        bit old_lock = m_lock;
        if (w) begin
            m_smi = old_lock && m_smien && !mg && d[0];
            if (!old_lock || mg || !d[0]) m_unlock = d[0];
            if (!old_lock) m_smien = d[2];
            m_lock = old_lock | d[1];
        end else begin
            m_smi = 1'b0;
        end
    endtask

    task automatic step(input bit w, input bit [2:0] d, input bit mg, input string tag);
        @(negedge clk);
        wr_en = w; wr_data = d; mgmt_mode = mg;
        @(posedge clk);
        model_edge(w, d, mg);
        @(negedge clk);
        wr_en = 1'b0; wr_data = 3'b000; mgmt_mode = 1'b0;
        compare(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_unlock = 0; m_lock = 0; m_smien = 0; m_smi = 0;
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        step(0, 3'b111, 1, "R2");       // strobe low: nothing changes
        step(1, 3'b001, 0, "R3");       // unlocked set from ordinary code
        step(0, 3'b000, 0, "R2");
        step(1, 3'b000, 0, "R6");
        step(1, 3'b011, 0, "R7");       // lock and unlock together: unlock lands
        step(1, 3'b000, 0, "R6");       // locked clear from ordinary code
        step(1, 3'b001, 0, "R5");       // blocked, smi_en still 0 -> no pulse
        step(1, 3'b101, 0, "R10");      // smi_en write ignored while locked
        step(1, 3'b001, 1, "R4");
        step(1, 3'b000, 1, "R6");
        step(1, 3'b001, 0, "R9");

        do_reset();
        step(1, 3'b101, 0, "R9");       // unlocked, smi_en set: no pulse
        step(1, 3'b110, 0, "R7");       // lock with smi_en kept
        step(1, 3'b001, 0, "R8");       // blocked attempt -> pulse
        step(0, 3'b000, 0, "R8");       // pulse gone
        step(1, 3'b001, 0, "R8");       // back-to-back attempts
        step(1, 3'b001, 0, "R8");
        step(1, 3'b000, 0, "R7");       // lock bit 0 written: lock stays
        step(1, 3'b001, 0, "R7");
        step(1, 3'b000, 0, "R10");      // attempt to clear smi_en while locked
        step(1, 3'b001, 0, "R10");      // still pulses
        step(1, 3'b001, 1, "R9");       // management unlock: no pulse
        step(1, 3'b001, 0, "R8");       // attempt while already unlocked
        step(0, 3'b000, 0, "R2");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule